// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block watches processor activity against a set of debug address slots and reports which slots hit. A single control word decides for every slot whether it is active, which kind of activity it watches (instruction fetch, data write, data read or write, I/O port access) and, for I/O slots, how many bytes the watched range spans. The block keeps the low hit bits and the single-step bit of a debug status word. It raises a one-cycle debug-exception request when a hit calls for one.

Three kinds of event enter the block. An instruction check compares instruction-type slots with the current instruction address and takes data-watch hit strobes from an external comparator. A single-step event runs the same comparison and always updates status and raises the exception. An I/O check compares the accessed port range with the enabled I/O slots. Every event is sampled on a rising clock edge, and its results appear on that same edge.

Top module: `dbg_match_unit`

## Requirements
- R1: Slot i is active when control bit 2i (local enable) or control bit 2i+1 (global enable) is set.
- R2: The 2-bit kind of slot i is control bits TYPE_BASE+4i+1:TYPE_BASE+4i (default base 16), coded 0 = instruction, 1 = data write, 2 = I/O access, 3 = data read/write. The 2-bit span code of slot i is at LEN_BASE+4i (default base 18), coded 0 = 1 byte, 1 = 2 bytes, 2 = 8 bytes, 3 = 4 bytes.
- R3: In an instruction check, an instruction slot matches only when its address equals the instruction address on all bits. A data slot (kind 1 or 3) matches when its data-hit strobe is high. An I/O slot never matches.
- R4: When the status is written by an instruction check, status bits 3:0 hold the match mask of that check, one bit per slot, including slots that are not active.
- R5: An instruction check writes the status only if an active slot matches or the force flag is high. Otherwise the status stays unchanged.
- R6: The exception request goes high on the edge that samples an instruction check with at least one active match, and only for one cycle. It stays low when only inactive slots match, even if force is high.
- R7: A single-step event writes status bits 3:0 with the instruction-check match mask whatever the enables are, sets status bit 14 (single-step) and raises the exception request.
- R8: An I/O slot hits when it is active and the range [port, port+size-1] overlaps [slot address, slot address+span-1]. The size is 1, 2 or 4 bytes, and the arithmetic does not wrap.
- R9: An I/O check replaces status bits 3:0 with the I/O hit mask, including an all-zero mask, and raises the exception request exactly when that mask is nonzero.
- R10: When events coincide, single-step wins over an I/O check, and an I/O check wins over an instruction check.
- R11: Synchronous reset sets the status to 16'h0FF0 and clears the exception request. Those fixed-one bits never change. The single-step bit, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | CTRL_W | Debug control word (enables, kinds, spans) |
| slot_addr_i | input | NUM_SLOTS*ADDR_W | Slot addresses, slot i at bits i*ADDR_W upward |
| pc_i | input | ADDR_W | Current instruction address |
| data_hit_i | input | NUM_SLOTS | Per-slot data-watch hit strobes |
| chk_i | input | 1 | Instruction check strobe |
| force_i | input | 1 | Force status update on instruction check |
| step_i | input | 1 | Single-step event |
| io_i | input | 1 | I/O access check strobe |
| io_port_i | input | PORT_W | Accessed port number |
| io_size_i | input | 3 | Access size in bytes (1, 2 or 4) |
| status_o | output | STAT_W | Debug status word |
| dbg_irq_o | output | 1 | Debug exception request pulse |

## Verification
The bench aims at the gap between recording a hit and acting on it. A design that gated the status bits with the enables would lose the marks of inactive slots under force. A design that raised the exception on force alone would fire with no active hit. The span decode is tested at both edges of the 8-byte and 4-byte ranges: a linear decode of code 2 or 3 would miss or add a hit one byte past the edge. Coinciding events and all-zero I/O masks show up a design that picks the wrong event or leaves stale hit bits behind.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;

   typedef enum logic [1:0] {
      BK_EXEC  = 2'd0,
      BK_WRITE = 2'd1,
      BK_IO    = 2'd2,
      BK_RDWR  = 2'd3
   } brk_kind_e;

   // span code to byte count; the order is not linear
   function automatic logic [3:0] span_bytes(input logic [1:0] code);
      case (code)
         2'd0:    span_bytes = 4'd1;
         2'd1:    span_bytes = 4'd2;
         2'd2:    span_bytes = 4'd8;
         default: span_bytes = 4'd4;
      endcase
   endfunction

endpackage

// File: rtl/dbgm_slot_decode.sv
module dbgm_slot_decode
   import dbgm_pkg::*;
#(
   parameter int CTRL_W    = 32,
   parameter int SLOT      = 0,
   parameter int TYPE_BASE = 16,
   parameter int LEN_BASE  = 18
) (
   input  logic [CTRL_W-1:0] ctrl_i,
   output logic              active_o,
   output brk_kind_e         kind_o,
   output logic [3:0]        span_o
);
   localparam int EN_POS   = 2 * SLOT;
   localparam int KIND_POS = TYPE_BASE + 4 * SLOT;
   localparam int SPAN_POS = LEN_BASE + 4 * SLOT;

   assign active_o = ctrl_i[EN_POS] | ctrl_i[EN_POS+1];
   assign kind_o   = brk_kind_e'(ctrl_i[KIND_POS +: 2]);
   assign span_o   = span_bytes(ctrl_i[SPAN_POS +: 2]);
endmodule

// File: rtl/dbgm_slot_match.sv
module dbgm_slot_match
   import dbgm_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PORT_W = 16
) (
   input  logic              active_i,
   input  brk_kind_e         kind_i,
   input  logic [3:0]        span_i,
   input  logic [ADDR_W-1:0] slot_addr_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              data_hit_i,
   input  logic [PORT_W-1:0] io_port_i,
   input  logic [2:0]        io_size_i,
   output logic              raw_hit_o,
   output logic              io_hit_o
);
   // widened so that range ends never wrap
   localparam int CMP_W = ADDR_W + 4;

   logic [CMP_W-1:0] port_lo, port_hi, slot_lo, slot_hi;

   always_comb begin
      port_lo = CMP_W'(io_port_i);
      port_hi = port_lo + CMP_W'(io_size_i) - CMP_W'(1);
      slot_lo = CMP_W'(slot_addr_i);
      slot_hi = slot_lo + CMP_W'(span_i) - CMP_W'(1);
   end

   always_comb begin
      case (kind_i)
         BK_EXEC:           raw_hit_o = (slot_addr_i == pc_i);
         BK_WRITE, BK_RDWR: raw_hit_o = data_hit_i;
         default:           raw_hit_o = 1'b0;
      endcase
   end

   assign io_hit_o = active_i && (kind_i == BK_IO) &&
                     (port_hi >= slot_lo) && (port_lo <= slot_hi);
endmodule

// File: rtl/dbgm_status_upd.sv
module dbgm_status_upd #(
   parameter int          STAT_W     = 16,
   parameter int          NUM_SLOTS  = 4,
   parameter int          STEP_BIT   = 14,
   parameter int unsigned STAT_FIXED = 32'h0FF0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 chk_i,
   input  logic                 force_i,
   input  logic                 step_i,
   input  logic                 io_i,
   input  logic [NUM_SLOTS-1:0] raw_mask_i,
   input  logic [NUM_SLOTS-1:0] en_mask_i,
   input  logic [NUM_SLOTS-1:0] io_mask_i,
   output logic [STAT_W-1:0]    status_o,
   output logic                 irq_o
);
   localparam logic [STAT_W-1:0] RST_VAL = STAT_W'(STAT_FIXED);

   logic [STAT_W-1:0] stat_q, stat_d;
   logic              irq_q, irq_d;
   logic              en_hit;

   assign en_hit = |(raw_mask_i & en_mask_i);

   always_comb begin
      stat_d = stat_q;
      irq_d  = 1'b0;
      if (step_i) begin
         stat_d[NUM_SLOTS-1:0] = raw_mask_i;
         stat_d[STEP_BIT]      = 1'b1;
         irq_d                 = 1'b1;
      end else if (io_i) begin
         stat_d[NUM_SLOTS-1:0] = io_mask_i;
         irq_d                 = |io_mask_i;
      end else if (chk_i) begin
         if (en_hit || force_i) stat_d[NUM_SLOTS-1:0] = raw_mask_i;
         irq_d = en_hit;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stat_q <= RST_VAL;
         irq_q  <= 1'b0;
      end else begin
         stat_q <= stat_d;
         irq_q  <= irq_d;
      end
   end

   assign status_o = stat_q;
   assign irq_o    = irq_q;
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
   import dbgm_pkg::*;
#(
   parameter int          NUM_SLOTS  = 4,
   parameter int          ADDR_W     = 32,
   parameter int          PORT_W     = 16,
   parameter int          CTRL_W     = 32,
   parameter int          TYPE_BASE  = 16,
   parameter int          LEN_BASE   = 18,
   parameter int          STAT_W     = 16,
   parameter int          STEP_BIT   = 14,
   parameter int unsigned STAT_FIXED = 32'h0FF0
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [CTRL_W-1:0]           ctrl_i,
   input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr_i,
   input  logic [ADDR_W-1:0]           pc_i,
   input  logic [NUM_SLOTS-1:0]        data_hit_i,
   input  logic                        chk_i,
   input  logic                        force_i,
   input  logic                        step_i,
   input  logic                        io_i,
   input  logic [PORT_W-1:0]           io_port_i,
   input  logic [2:0]                  io_size_i,
   output logic [STAT_W-1:0]           status_o,
   output logic                        dbg_irq_o
);
   localparam int KIND_TOP = TYPE_BASE + 4 * (NUM_SLOTS - 1) + 1;
   localparam int SPAN_TOP = LEN_BASE + 4 * (NUM_SLOTS - 1) + 1;
   localparam int EN_TOP   = 2 * NUM_SLOTS - 1;
   localparam logic [STAT_W-1:0] FIX_V = STAT_W'(STAT_FIXED);

   // elaboration-time parameter checks
   if (KIND_TOP >= CTRL_W || SPAN_TOP >= CTRL_W) begin : g_bad_fields
      $error("kind or span field lies outside the control word");
   end
   if (EN_TOP >= TYPE_BASE || EN_TOP >= LEN_BASE) begin : g_bad_enables
      $error("enable bits overlap the kind or span fields");
   end
   if (PORT_W > ADDR_W) begin : g_bad_port
      $error("port width exceeds address width");
   end
   if (NUM_SLOTS > STEP_BIT || STEP_BIT >= STAT_W) begin : g_bad_status
      $error("status layout does not fit");
   end
   if ((FIX_V[NUM_SLOTS-1:0] != '0) || FIX_V[STEP_BIT]) begin : g_bad_fixed
      $error("fixed-one pattern collides with live status bits");
   end

   logic [NUM_SLOTS-1:0] en_mask, raw_mask, io_mask;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic       act;
      brk_kind_e  kind;
      logic [3:0] span;

      dbgm_slot_decode #(
         .CTRL_W(CTRL_W), .SLOT(s), .TYPE_BASE(TYPE_BASE), .LEN_BASE(LEN_BASE)
      ) u_dec (
         .ctrl_i  (ctrl_i),
         .active_o(act),
         .kind_o  (kind),
         .span_o  (span)
      );

      dbgm_slot_match #(
         .ADDR_W(ADDR_W), .PORT_W(PORT_W)
      ) u_cmp (
         .active_i   (act),
         .kind_i     (kind),
         .span_i     (span),
         .slot_addr_i(slot_addr_i[s*ADDR_W +: ADDR_W]),
         .pc_i       (pc_i),
         .data_hit_i (data_hit_i[s]),
         .io_port_i  (io_port_i),
         .io_size_i  (io_size_i),
         .raw_hit_o  (raw_mask[s]),
         .io_hit_o   (io_mask[s])
      );

      assign en_mask[s] = act;
   end

   dbgm_status_upd #(
      .STAT_W(STAT_W), .NUM_SLOTS(NUM_SLOTS),
      .STEP_BIT(STEP_BIT), .STAT_FIXED(STAT_FIXED)
   ) u_stat (
      .clk       (clk),
      .rst       (rst),
      .chk_i     (chk_i),
      .force_i   (force_i),
      .step_i    (step_i),
      .io_i      (io_i),
      .raw_mask_i(raw_mask),
      .en_mask_i (en_mask),
      .io_mask_i (io_mask),
      .status_o  (status_o),
      .irq_o     (dbg_irq_o)
   );
endmodule

// File: rtl/dbgm_checker.sv
module dbgm_checker #(
   parameter int          STAT_W     = 16,
   parameter int          NUM_SLOTS  = 4,
   parameter int          STEP_BIT   = 14,
   parameter int unsigned STAT_FIXED = 32'h0FF0
) (
   input logic              clk,
   input logic              rst,
   input logic              chk_i,
   input logic              force_i,
   input logic              step_i,
   input logic              io_i,
   input logic [STAT_W-1:0] status_o,
   input logic              dbg_irq_o
);
   localparam logic [STAT_W-1:0] FX = STAT_W'(STAT_FIXED);

   logic any_ev;
   assign any_ev = chk_i | step_i | io_i;

   a_r11_fixed_kept: assert property (@(posedge clk) disable iff (rst)
      (status_o & FX) == FX);

   a_r11_step_sticky: assert property (@(posedge clk) disable iff (rst)
      status_o[STEP_BIT] |=> status_o[STEP_BIT]);

   a_r7_step_raises: assert property (@(posedge clk) disable iff (rst)
      step_i |=> (dbg_irq_o && status_o[STEP_BIT]));

   a_r9_io_irq_mask: assert property (@(posedge clk) disable iff (rst)
      (io_i && !step_i) |=> (dbg_irq_o == (status_o[NUM_SLOTS-1:0] != '0)));

   a_r6_no_event_no_irq: assert property (@(posedge clk) disable iff (rst)
      !any_ev |=> !dbg_irq_o);

   a_r5_idle_status_stable: assert property (@(posedge clk) disable iff (rst)
      !any_ev |=> $stable(status_o));

   a_r5_unforced_quiet: assert property (@(posedge clk) disable iff (rst)
      (chk_i && !force_i && !step_i && !io_i) |=> (dbg_irq_o || $stable(status_o)));
endmodule

bind dbg_match_unit dbgm_checker #(
   .STAT_W(STAT_W), .NUM_SLOTS(NUM_SLOTS),
   .STEP_BIT(STEP_BIT), .STAT_FIXED(STAT_FIXED)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .chk_i    (chk_i),
   .force_i  (force_i),
   .step_i   (step_i),
   .io_i     (io_i),
   .status_o (status_o),
   .dbg_irq_o(dbg_irq_o)
);

// File: tb/sim_dbg_match_unit.sv
module sim_dbg_match_unit;
   localparam int NS = 4;
   localparam int AW = 32;
   localparam int PW = 16;
   localparam int CW = 32;
   localparam int SB = 14;
   localparam logic [15:0] FX = 16'h0FF0;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic [CW-1:0]    ctrl = '0;
   logic [AW-1:0]    sa [NS];
   logic [NS*AW-1:0] sa_flat;
   logic [AW-1:0]    pc = '0;
   logic [NS-1:0]    dhit = '0;
   logic             c_chk = 0, c_force = 0, c_step = 0, c_io = 0;
   logic [PW-1:0]    port = '0;
   logic [2:0]       psize = 3'd1;
   logic [15:0]      status;
   logic             irq;

   always_comb for (int i = 0; i < NS; i++) sa_flat[i*AW +: AW] = sa[i];

   dbg_match_unit u0 (
      .clk(clk), .rst(rst), .ctrl_i(ctrl), .slot_addr_i(sa_flat), .pc_i(pc),
      .data_hit_i(dhit), .chk_i(c_chk), .force_i(c_force), .step_i(c_step),
      .io_i(c_io), .io_port_i(port), .io_size_i(psize),
      .status_o(status), .dbg_irq_o(irq)
   );

   int checks = 0;
   int fails  = 0;
   logic [15:0] exp_st;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // model functions built from the requirements
   function automatic logic [NS-1:0] m_en();
      for (int i = 0; i < NS; i++) m_en[i] = ctrl[2*i] | ctrl[2*i+1];
   endfunction

   function automatic logic [1:0] m_kind(input int i);
      return ctrl[16 + 4*i +: 2];
   endfunction

   function automatic longint m_span(input int i);
      case (ctrl[18 + 4*i +: 2])
         2'd0: return 1;
         2'd1: return 2;
         2'd2: return 8;
         default: return 4;
      endcase
   endfunction

   function automatic logic [NS-1:0] m_raw();
      for (int i = 0; i < NS; i++) begin
         case (m_kind(i))
            2'd0: m_raw[i] = (sa[i] == pc);
            2'd1, 2'd3: m_raw[i] = dhit[i];
            default: m_raw[i] = 1'b0;
         endcase
      end
   endfunction

   function automatic logic [NS-1:0] m_io();
      logic [NS-1:0] en;
      en = m_en();
      for (int i = 0; i < NS; i++) begin
         longint plo, phi, slo, shi;
         plo = longint'(port);
         phi = plo + longint'(psize) - 1;
         slo = longint'(sa[i]);
         shi = slo + m_span(i) - 1;
         m_io[i] = en[i] && (m_kind(i) == 2'd2) && (phi >= slo) && (plo <= shi);
      end
   endfunction

   // apply one event set for one cycle, then check result and pulse end
   task automatic fire(input bit c, input bit f, input bit s, input bit o, input string req);
      logic [NS-1:0] raw, en, iom;
      logic exp_irq;
      raw = m_raw(); en = m_en(); iom = m_io();
      exp_irq = 1'b0;
      if (s) begin
         exp_st[NS-1:0] = raw; exp_st[SB] = 1'b1; exp_irq = 1'b1;
      end else if (o) begin
         exp_st[NS-1:0] = iom; exp_irq = |iom;
      end else if (c) begin
         if ((|(raw & en)) || f) exp_st[NS-1:0] = raw;
         exp_irq = |(raw & en);
      end
      @(negedge clk);
      c_chk = c; c_force = f; c_step = s; c_io = o;
      @(negedge clk);
      c_chk = 0; c_force = 0; c_step = 0; c_io = 0;
      check({req, " status"}, 32'(status), 32'(exp_st));
      check({req, " irq"}, 32'(irq), 32'(exp_irq));
      @(negedge clk);
      check("R6 pulse ends", 32'(irq), 32'd0);
      check("R5 idle status", 32'(status), 32'(exp_st));
   endtask

   function automatic logic [CW-1:0] mk_ctrl(input logic [1:0] k0, input logic [1:0] s0,
                                             input logic [1:0] e0);
      logic [CW-1:0] v;
      v = '0;
      v[1:0] = e0;
      v[17:16] = k0;
      v[19:18] = s0;
      return v;
   endfunction

   bit done = 0;

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < NS; i++) sa[i] = 32'h1000 + 32'(i);
      repeat (3) @(negedge clk);
      check("R11 reset status", 32'(status), 32'(FX));
      check("R11 reset irq", 32'(irq), 32'd0);
      rst = 0;
      exp_st = FX;
      @(negedge clk);

      // R3/R5: inactive instruction slot matches, no force: nothing changes
      ctrl = mk_ctrl(2'd0, 2'd0, 2'b00);
      sa[0] = 32'hDEAD_BEEF; pc = 32'hDEAD_BEEF;
      fire(1, 0, 0, 0, "R5 inactive hit unforced");
      check("R5 low bits untouched", 32'(status[3:0]), 32'd0);
      // R4/R6: same with force, status records hit, no irq
      fire(1, 1, 0, 0, "R4 forced inactive hit");
      check("R4 hit bit kept", 32'(status[0]), 32'd1);
      // R1: local enable, then global enable
      ctrl = mk_ctrl(2'd0, 2'd0, 2'b01);
      fire(1, 0, 0, 0, "R1 local enable");
      ctrl = mk_ctrl(2'd0, 2'd0, 2'b10);
      fire(1, 0, 0, 0, "R1 global enable");
      // R3: one address bit off never matches
      pc = 32'hDEAD_BEEF ^ 32'h8000_0000;
      fire(1, 1, 0, 0, "R3 near miss");
      check("R3 no hit bit", 32'(status[0]), 32'd0);
      // R2/R8: span code 2 is 8 bytes
      ctrl = mk_ctrl(2'd2, 2'd2, 2'b01);
      sa[0] = 32'd8; port = 16'd15; psize = 3'd1;
      fire(0, 0, 0, 1, "R8 span8 last byte");
      port = 16'd16;
      fire(0, 0, 0, 1, "R8 span8 past end");
      // R2/R8: span code 3 is 4 bytes
      ctrl = mk_ctrl(2'd2, 2'd3, 2'b10);
      port = 16'd11;
      fire(0, 0, 0, 1, "R8 span4 last byte");
      port = 16'd12;
      fire(0, 0, 0, 1, "R9 zero mask clears");
      check("R9 cleared bits", 32'(status[3:0]), 32'd0);
      // R8: access starting below the slot overlaps by its tail
      port = 16'd5; psize = 3'd4;
      fire(0, 0, 0, 1, "R8 tail overlap");
      // R8: inactive I/O slot never hits
      ctrl = mk_ctrl(2'd2, 2'd3, 2'b00);
      fire(0, 0, 0, 1, "R8 inactive io");
      // R10: step wins over io and check
      ctrl = mk_ctrl(2'd2, 2'd3, 2'b01);
      fire(1, 0, 1, 1, "R10 step over io");
      check("R7 step bit", 32'(status[SB]), 32'd1);
      // R10: io wins over instruction check
      fire(1, 1, 0, 1, "R10 io over check");

      // random mix
      for (int n = 0; n < 400; n++) begin
         int sel;
         ctrl = $urandom();
         for (int i = 0; i < NS; i++)
            sa[i] = ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 40)) : $urandom();
         pc    = ($urandom_range(0, 1) != 0) ? sa[$urandom_range(0, NS-1)] : 32'($urandom_range(0, 40));
         dhit  = NS'($urandom());
         port  = PW'($urandom_range(0, 48));
         case ($urandom_range(0, 2))
            0: psize = 3'd1;
            1: psize = 3'd2;
            default: psize = 3'd4;
         endcase
         sel = $urandom_range(0, 9);
         if (sel < 5)      fire(1, ($urandom_range(0, 1) != 0), 0, 0, "R4 R5 R6 random check");
         else if (sel < 8) fire(0, 0, 0, 1, "R8 R9 random io");
         else if (sel < 9) fire(1, 0, 1, 0, "R7 random step");
         else              fire(1, 1, 0, 1, "R10 random overlap");
      end
      check("R11 fixed bits", 32'(status & FX), 32'(FX));

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule